// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle peripheral register bus. Software picks a reload constant and sets an enable bit. It then services the watchdog by writing a two-byte key to a feed register. Each completed key reloads a down-counter. The first completed key taken while the enable bit is set arms the watchdog.

Once the watchdog is armed, two things trigger it. One is the counter expiring. The other is a broken key sequence, meaning any bus access after the first key byte other than the second key byte written to the feed register. A trigger raises a level interrupt that stays high until software clears the timeout flag. It also raises a one-cycle reset-request pulse when reset generation is enabled. Before the watchdog is armed, it stays silent.

Top module: `wdog_feed_timer`

## Requirements
- R1: After reset the mode register (offset 0x0) reads 0, the reload register (offset 0x4) reads 0xFF, the count register (offset 0xC) reads 0xFF, and `irq` and `rst_req` are low.
- R2: A write to the reload register of a value below 0xFF stores 0xFF. Any other value is stored as written.
- R3: Writing byte 0xAA and then byte 0x55 (`bus_wdata[7:0]`) to the feed register (offset 0x8) loads the counter from the reload register, whether or not the enable bit is set. The feed register reads as 0.
- R4: The counter holds its value until a completed feed happens while mode bit 0 (enable) is 1. Setting the enable bit alone does not start it.
- R5: Once armed, the counter falls by one every fourth clock. The first decrement lands on the fourth rising edge after the edge that completed the feed.
- R6: When the armed counter reaches 0, it stops there. Mode bit 2 (timeout flag) and `irq` rise on that edge, and `rst_req` pulses high for exactly one cycle if mode bit 1 (reset enable) is 1.
- R7: Before the first arming feed, broken key sequences and counter activity raise neither `irq` nor `rst_req`.
- R8: Once armed, an access after 0xAA that is not a feed write of 0x55 (or 0xAA) raises `irq` in the second clock after that access. `rst_req` pulses in the same cycle if reset enable is set.
- R9: A feed write of 0xAA while a key sequence is already open restarts the sequence and is not an error.
- R10: Once armed, writes of 0 to the enable and reset-enable bits are ignored. Before arming, both bits follow writes.
- R11: Writing 0 to mode bit 2 clears the timeout flag and drops `irq`. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe; one access per cycle in which it is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Timeout interrupt, level, follows the timeout flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions take for granted that every cycle with `bus_sel` high is exactly one complete access, and that the address, direction and data are known and steady in that cycle. They also assume `rst_n` is held low for at least one rising edge before any access. The stimulus meets these conditions by changing bus inputs only on falling edges, and by keeping each access to a single clock. Each scenario begins from a fresh reset, because the enable bits cannot be cleared by software once the watchdog is armed.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the keyed-feed watchdog.
// Assumes a 32-bit register bus addressed by a 4-bit byte offset.
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_FEED   = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'hC;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int MODE_EN  = 0;
    localparam int MODE_RST = 1;
    localparam int MODE_TMO = 2;
endpackage

// File: rtl/wdt_feed_seq.sv
// Module: tracks the two-byte feed key, arms the watchdog and flags broken
// sequences. Assumes each cycle with acc_i high is one bus access.
// Errors are reported through a one-stage pipeline so that the trigger lands
// in the second clock after the offending access.
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_i,
    input  logic       wr_i,
    input  logic       is_feed_i,
    input  logic [7:0] byte_i,
    input  logic       en_i,
    output logic       feed_done_o,
    output logic       armed_o,
    output logic       err_o
);
    logic pending_q;
    logic armed_q;
    logic err_q;
    logic feed_wr;
    logic key1_wr;
    logic key2_wr;
    logic err_now;

    assign feed_wr     = acc_i && wr_i && is_feed_i;
    assign key1_wr     = feed_wr && (byte_i == KEY_FIRST);
    assign key2_wr     = feed_wr && (byte_i == KEY_SECOND);
    assign feed_done_o = key2_wr && pending_q;
    assign err_now     = acc_i && pending_q && armed_q && !key1_wr && !key2_wr;

    // Open the sequence on the first key byte; close it on any other access.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending_q <= 1'b0;
        else if (acc_i) pending_q <= key1_wr;
    end

    // Arm on the first completed feed taken while enabled; only reset disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed_q <= 1'b0;
        else if (feed_done_o && en_i) armed_q <= 1'b1;
    end

    // Delay a broken-sequence error by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_now;
    end

    assign armed_o = armed_q;
    assign err_o   = err_q;

    // R8: an error stage never follows an unarmed watchdog
    p_err_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> armed_q);
endmodule

// File: rtl/wdt_down_counter.sv
// Module: fixed prescaler and down-counter. Assumes load_i is a single-cycle
// strobe. The counter runs only while armed_i is high, stops at zero, and
// reports the step into zero as a one-cycle event.
module wdt_down_counter #(
    parameter int CNT_W      = 32,
    parameter int DIV        = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick     = armed_i && (pre_q == PRE_LAST);
    assign expire_o = tick && !load_i && (cnt_q == CNT_W'(1));

    // Prescaler: restart on load, count while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) pre_q <= '0;
        else if (tick)        pre_q <= '0;
        else if (armed_i)     pre_q <= pre_q + 1'b1;
    end

    // Counter: reload on feed, step down on tick, hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= CNT_W'(RELOAD_MIN);
        else if (load_i)                 cnt_q <= reload_i;
        else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;

    // R4: without arming or load the count never moves
    p_hold_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_i && !load_i) |=> $stable(cnt_q));
    // R5: without load the count moves down by at most one per clock
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wdt_regs.sv
// Module: mode and reload registers, timeout flag, reset pulse and read mux.
// Assumes trigger_i is a one-cycle event from the counter or the feed checker.
// Enable bits become sticky once armed_i is high.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              armed_i,
    input  logic              trigger_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              en_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              flag_o,
    output logic              rst_req_o
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(RELOAD_MIN);

    logic             en_q;
    logic             rsten_q;
    logic             flag_q;
    logic             rst_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] wr_val;
    logic             mode_wr;
    logic             reload_wr;

    assign mode_wr   = acc_i && wr_i && (addr_i == OFS_MODE);
    assign reload_wr = acc_i && wr_i && (addr_i == OFS_RELOAD);
    assign wr_val    = CNT_W'(wdata_i);

    // Enable bits: follow writes until armed, then only accept ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rsten_q <= 1'b0;
        end else if (mode_wr) begin
            en_q    <= wdata_i[MODE_EN]  | (armed_i & en_q);
            rsten_q <= wdata_i[MODE_RST] | (armed_i & rsten_q);
        end
    end

    // Timeout flag: set by a trigger, cleared by writing zero; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (trigger_i)                  flag_q <= 1'b1;
        else if (mode_wr && !wdata_i[MODE_TMO]) flag_q <= 1'b0;
    end

    // Reset request: one-cycle pulse per trigger when reset is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= trigger_i && rsten_q;
    end

    // Reload constant with a lower floor.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= FLOOR;
        else if (reload_wr) reload_q <= (wr_val < FLOOR) ? FLOOR : wr_val;
    end

    // Read mux; the feed register and unmapped offsets read zero.
    always_comb begin
        unique case (addr_i)
            OFS_MODE:   rdata_o = DATA_W'({flag_q, rsten_q, en_q});
            OFS_RELOAD: rdata_o = DATA_W'(reload_q);
            OFS_COUNT:  rdata_o = DATA_W'(count_i);
            default:    rdata_o = '0;
        endcase
    end

    assign en_o      = en_q;
    assign reload_o  = reload_q;
    assign flag_o    = flag_q;
    assign rst_req_o = rst_q;

    // R10: enable bits cannot be dropped while armed
    p_sticky_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && en_q) |=> en_q);
    p_sticky_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && rsten_q) |=> rsten_q);
    // R6: a reset pulse only appears with reset enable set
    p_rst_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> rsten_q);
endmodule

// File: rtl/wdog_feed_timer.sv
// Module: top of the keyed-feed watchdog. Joins the feed checker, the
// counter and the register file. Assumes one access per cycle with bus_sel
// high, and at least one edge of reset before use.
module wdog_feed_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DIV        = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic             en;
    logic             armed;
    logic             feed_done;
    logic             feed_err;
    logic             expire;
    logic             trigger;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;

    assign trigger = expire || feed_err;

    wdt_feed_seq u_feed (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (bus_sel),
        .wr_i        (bus_write),
        .is_feed_i   (bus_addr == OFS_FEED),
        .byte_i      (bus_wdata[7:0]),
        .en_i        (en),
        .feed_done_o (feed_done),
        .armed_o     (armed),
        .err_o       (feed_err)
    );

    wdt_down_counter #(
        .CNT_W      (CNT_W),
        .DIV        (DIV),
        .RELOAD_MIN (RELOAD_MIN)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .load_i   (feed_done),
        .reload_i (reload),
        .count_o  (count),
        .expire_o (expire)
    );

    wdt_regs #(
        .CNT_W      (CNT_W),
        .RELOAD_MIN (RELOAD_MIN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (bus_sel),
        .wr_i      (bus_write),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .armed_i   (armed),
        .trigger_i (trigger),
        .count_i   (count),
        .en_o      (en),
        .reload_o  (reload),
        .rdata_o   (bus_rdata),
        .flag_o    (irq),
        .rst_req_o (rst_req)
    );

    // R7: nothing fires before arming
    p_quiet_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!irq && !rst_req));
    // R8: the delayed error stage raises the interrupt on the next edge
    p_err_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        feed_err |=> irq);
    // R11: a clearing write with no trigger drops the interrupt
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_write && bus_addr == OFS_MODE && !bus_wdata[MODE_TMO]
         && !trigger) |=> !irq);
endmodule

// File: tb/wdog_feed_timer_tb_top.sv
// Directed bench: one task per scenario, each starting from a fresh reset.
module wdog_feed_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_write;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    wdog_feed_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(4'h0, v); chk("R1 mode", v, 32'h0);
        rd(4'h4, v); chk("R1 reload", v, 32'hFF);
        rd(4'hC, v); chk("R1 count", v, 32'hFF);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_reload_clamp();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h10);   rd(4'h4, v); chk("R2 clamp", v, 32'hFF);
        wr(4'h4, 32'h1234); rd(4'h4, v); chk("R2 plain", v, 32'h1234);
    endtask

    task automatic t_unarmed();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h300);
        feed();
        rd(4'hC, v); chk("R3 load without enable", v, 32'h300);
        rd(4'h8, v); chk("R3 feed reads zero", v, 32'h0);
        idle(20);
        rd(4'hC, v); chk("R4 no count without enable", v, 32'h300);
        wr(4'h0, 32'h3);
        idle(20);
        rd(4'hC, v); chk("R4 enable alone holds", v, 32'h300);
        wr(4'h8, 32'hAA);
        wr(4'h4, 32'h400);
        idle(4);
        chk("R7 irq quiet", irq, 0);
        chk("R7 rst quiet", rst_req, 0);
        rd(4'h0, v); chk("R7 flag clear", v, 32'h3);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R10 bits follow before arming", v, 32'h0);
    endtask

    task automatic t_rate();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h100);
        wr(4'h0, 32'h1);
        feed();
        rd(4'hC, v); chk("R5 loaded", v, 32'h100);
        idle(2);
        rd(4'hC, v); chk("R5 before tick", v, 32'h100);
        rd(4'hC, v); chk("R5 first tick", v, 32'hFF);
        idle(3);
        rd(4'hC, v); chk("R5 second tick", v, 32'hFE);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int k;
        do_reset();
        wr(4'h0, 32'h3);
        feed();
        k = 0;
        while (!irq && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk("R6 expiry delay", k, 1020);
        chk("R6 rst pulse", rst_req, 1);
        idle(1);
        chk("R6 rst one cycle", rst_req, 0);
        chk("R6 irq held", irq, 1);
        rd(4'h0, v); chk("R6 flag", v, 32'h7);
        idle(8);
        rd(4'hC, v); chk("R6 stops at zero", v, 32'h0);
        chk("R6 no second pulse", rst_req, 0);
    endtask

    task automatic t_feed_error();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h3);
        feed();
        wr(4'h8, 32'hAA);
        rd(4'h0, v);
        chk("R8 not yet irq", irq, 0);
        chk("R8 not yet rst", rst_req, 0);
        idle(1);
        chk("R8 irq second clock", irq, 1);
        chk("R8 rst second clock", rst_req, 1);
        idle(1);
        chk("R8 rst drops", rst_req, 0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h100);
        wr(4'h0, 32'h3);
        feed();
        idle(12);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
        rd(4'hC, v); chk("R9 restart reloads", v, 32'h100);
        idle(3);
        chk("R9 no irq", irq, 0);
        chk("R9 no rst", rst_req, 0);
    endtask

    task automatic t_sticky_and_clear();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h3);
        feed();
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R10 sticky bits", v, 32'h3);
        do_reset();
        wr(4'h0, 32'h1);
        feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h12);
        chk("R8 rst off no pulse", rst_req, 0);
        idle(1);
        chk("R11 irq raised", irq, 1);
        chk("R11 rst stays low", rst_req, 0);
        wr(4'h0, 32'h5);
        chk("R11 write one keeps", irq, 1);
        wr(4'h0, 32'h0);
        chk("R11 cleared", irq, 0);
        rd(4'h0, v); chk("R11 mode after clear", v, 32'h1);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_reload_clamp();
        t_unarmed();
        t_rate();
        t_timeout();
        t_feed_error();
        t_restart();
        t_sticky_and_clear();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule